// File: doc/BRIEF.md
# Serial Control Register Port

This block is the control-register front end of an audio converter core. An external host drives a four-wire serial link: select (`cs_n`, active low), serial clock, data in and data out. Every transaction is one 16-bit word, sent most significant bit first. Bits [15:12] carry a register address. Bit 11 selects read (1) or write (0). Bit 10 is reserved. Bits [9:0] carry the data field.

The serial clock has no fixed relation to the core clock or to the audio frame clock. A write word is accepted only when select rises after exactly 16 rising serial-clock edges. The accepted word is handed into the core domain by a toggle handshake and is then applied to a bank of 10-bit control registers.

A read word returns a value in the data field of the same frame. The value comes from a control register or from one of the peak-level inputs.

An active-low combined power-down/reset loads every register with its default value. It also starts a clear window that lasts a set number of frame-clock periods. While the window is open, the `busy` output is high and completed writes are thrown away. All pins are plain level or strobe pins. A transaction is one self-contained word, so no valid/ready handshake or back-pressure exists at either edge.

Top module: `ctl_port`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, register i (0 to NREG-1) holds the default (37*i + 5) mod 1024, and `busy` is 1.
- R2: After `rst_n` rises, `busy` stays 1 until CLEAR_FRAMES core-clock cycles with `frame_tick` high have been seen. In the core cycle that follows the last of those ticks, `busy` is 0. It then stays 0 until the next reset.
- R3: A write word applies its data bits [9:0] to register `addr` (bits [15:12]) within 8 core-clock cycles of `cs_n` rising. A write word has bit 11 = 0, is shifted in MSB first on rising serial-clock edges, and ends after exactly 16 edges.
- R4: A frame that ends after any number of rising serial-clock edges other than 16 changes no register.
- R5: A write that completes while `busy` is 1 is discarded. The register keeps its value after the window closes.
- R6: A read word (bit 11 = 1) changes no register. During the same frame, `sdo` presents the selected 10-bit value MSB first. Each bit changes on a falling edge, so that bits 9..0 are valid at rising edges 7 to 16.
- R7: Address PEAK_BASE + k, where PEAK_BASE = 16 - NPEAK, reads peak input k, which is `peak_lvl[10k +: 10]`. Any other address at or above NREG reads 0. Writes to any address at or above NREG change no register.
- R8: `sdo` is 0 whenever `cs_n` is high, during a write frame, and during the first six bit times of a read frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low power-down/reset, asynchronous |
| frame_tick | input | 1 | One core-cycle strobe per frame-clock period |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| peak_lvl | input | NPEAK*10 | Peak-detector levels, 10 bits per channel |
| regs_q | output | NREG*10 | Control register contents, register i at [10i +: 10] |
| busy | output | 1 | High during the post-reset clear window |

## Verification
The bench builds the block with its defaults: NREG = 8, NPEAK = 2 and CLEAR_FRAMES = 20. With these values, addresses 8 to 13 decode to no register and 14 and 15 decode to the peak inputs, so every address class can be reached with 4-bit addresses. A frame strobe every few core cycles closes the 20-frame window in a few hundred cycles. This lets the bench watch the exact tick that clears `busy`, send a write inside the window, and still leave time for the write, read, bad-count and second-reset cases. The serial clock runs at 12.5 MHz, four core cycles per bit, which places the shift and read-out edges between core edges.

// File: rtl/ctlp_pkg.sv
`timescale 1ns/1ps
package ctlp_pkg;
  localparam int WORD_W = 16;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 10;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              rd;
    logic              rsv;
    logic [DATA_W-1:0] data;
  } ctl_word_t;

  // default contents of control register idx
  function automatic logic [DATA_W-1:0] reg_default(input int idx);
    return DATA_W'(idx * 37 + 5);
  endfunction
endpackage

// File: rtl/ctlp_shift.sv
`timescale 1ns/1ps
module ctlp_shift
  import ctlp_pkg::*;
#(
  parameter int NREG  = 8,
  parameter int NPEAK = 2
) (
  input  logic                    rst_n,
  input  logic                    cs_n,
  input  logic                    sclk,
  input  logic                    sdi,
  output logic                    sdo,
  input  logic [NREG*DATA_W-1:0]  regs_i,
  input  logic [NPEAK*DATA_W-1:0] peak_i,
  output ctl_word_t               hold_o,
  output logic                    tgl_o
);
  localparam int PEAK_BASE = (1 << ADDR_W) - NPEAK;
  localparam int CNT_W     = $clog2(WORD_W) + 1;
  localparam int CNT_MAX   = (1 << CNT_W) - 1;
  // bits seen when the read flag has just been taken (addr + rd + rsv)
  localparam int RD_AT     = ADDR_W + 2;

  logic [WORD_W-1:0] sr;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] out_sr;
  logic              rd_act;
  logic [DATA_W-1:0] rd_val;
  logic [ADDR_W-1:0] rd_addr;

  // input shift, rising edge, MSB first
  always_ff @(posedge sclk) begin
    if (!cs_n) sr <= {sr[WORD_W-2:0], sdi};
  end

  // edge count, cleared while select is high, saturates
  always_ff @(posedge sclk or posedge cs_n) begin
    if (cs_n) cnt <= '0;
    else if (cnt != CNT_W'(CNT_MAX)) cnt <= cnt + 1'b1;
  end

  // commit on select release: only full-length write words
  always_ff @(posedge cs_n or negedge rst_n) begin
    if (!rst_n) begin
      tgl_o  <= 1'b0;
      hold_o <= '0;
    end else if (cnt == CNT_W'(WORD_W) && !sr[WORD_W-ADDR_W-1]) begin
      hold_o <= ctl_word_t'(sr);
      tgl_o  <= ~tgl_o;
    end
  end

  // read source select: address sits above the rd and rsv bits
  assign rd_addr = sr[RD_AT-1:2];

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NREG; i++)
      if (rd_addr == ADDR_W'(i)) rd_val = regs_i[i*DATA_W +: DATA_W];
    for (int k = 0; k < NPEAK; k++)
      if (rd_addr == ADDR_W'(PEAK_BASE + k)) rd_val = peak_i[k*DATA_W +: DATA_W];
  end

  // output shift, falling edge
  always_ff @(negedge sclk or posedge cs_n) begin
    if (cs_n) begin
      out_sr <= '0;
      rd_act <= 1'b0;
    end else if (cnt == CNT_W'(RD_AT)) begin
      out_sr <= rd_val;
      rd_act <= sr[1];
    end else begin
      out_sr <= {out_sr[DATA_W-2:0], 1'b0};
    end
  end

  assign sdo = rd_act & out_sr[DATA_W-1];
endmodule

// File: rtl/ctlp_tsync.sv
`timescale 1ns/1ps
module ctlp_tsync (
  input  logic clk,
  input  logic rst_n,
  input  logic tgl_i,
  output logic pulse_o
);
  logic [2:0] s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s <= '0;
    else        s <= {s[1:0], tgl_i};
  end

  assign pulse_o = s[2] ^ s[1];

  // one commit yields exactly one core pulse
  p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |=> !pulse_o);
endmodule

// File: rtl/ctlp_bank.sv
`timescale 1ns/1ps
module ctlp_bank
  import ctlp_pkg::*;
#(
  parameter int NREG         = 8,
  parameter int CLEAR_FRAMES = 20
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   frame_tick,
  input  logic                   wr_pulse,
  input  ctl_word_t              wr_word,
  output logic [NREG*DATA_W-1:0] regs_o,
  output logic                   busy_o
);
  localparam int FC_W = $clog2(CLEAR_FRAMES + 1);

  logic [FC_W-1:0] fcnt;
  logic            wr_ok;

  // clear window counted in frame periods
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o <= 1'b1;
      fcnt   <= '0;
    end else if (busy_o && frame_tick) begin
      if (fcnt == FC_W'(CLEAR_FRAMES - 1)) busy_o <= 1'b0;
      fcnt <= fcnt + 1'b1;
    end
  end

  assign wr_ok = wr_pulse && !busy_o;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs_o[i*DATA_W +: DATA_W] <= reg_default(i);
      else if (wr_ok && wr_word.addr == ADDR_W'(i))
        regs_o[i*DATA_W +: DATA_W] <= wr_word.data;
    end

    p_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_pulse && !busy_o && wr_word.addr == ADDR_W'(i)) |=>
        regs_o[i*DATA_W +: DATA_W] == $past(wr_word.data));
  end

  p_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_pulse |=> $stable(regs_o));

  p_drop_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pulse && busy_o) |=> $stable(regs_o));

  p_busy_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |=> !busy_o);
endmodule

// File: rtl/ctl_port.sv
`timescale 1ns/1ps
module ctl_port
  import ctlp_pkg::*;
#(
  parameter int NREG         = 8,
  parameter int NPEAK        = 2,
  parameter int CLEAR_FRAMES = 20
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    frame_tick,
  input  logic                    cs_n,
  input  logic                    sclk,
  input  logic                    sdi,
  output logic                    sdo,
  input  logic [NPEAK*DATA_W-1:0] peak_lvl,
  output logic [NREG*DATA_W-1:0]  regs_q,
  output logic                    busy
);
  ctl_word_t hold;
  logic      tgl;
  logic      wr_pulse;

  ctlp_shift #(.NREG(NREG), .NPEAK(NPEAK)) u_shift (
    .rst_n (rst_n),
    .cs_n  (cs_n),
    .sclk  (sclk),
    .sdi   (sdi),
    .sdo   (sdo),
    .regs_i(regs_q),
    .peak_i(peak_lvl),
    .hold_o(hold),
    .tgl_o (tgl)
  );

  ctlp_tsync u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .tgl_i  (tgl),
    .pulse_o(wr_pulse)
  );

  ctlp_bank #(.NREG(NREG), .CLEAR_FRAMES(CLEAR_FRAMES)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_tick(frame_tick),
    .wr_pulse  (wr_pulse),
    .wr_word   (hold),
    .regs_o    (regs_q),
    .busy_o    (busy)
  );
endmodule

// File: tb/ctl_port_test.sv
`timescale 1ns/1ps
module ctl_port_test;
  localparam int NREG = 8;
  localparam int NPEAK = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_tick = 1'b0;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic sdi = 1'b0;
  logic sdo;
  logic [NPEAK*10-1:0] peak_lvl = '0;
  logic [NREG*10-1:0] regs_q;
  logic busy;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [9:0] model [NREG];

  always #10 clk = ~clk;

  ctl_port uut (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .cs_n(cs_n),
    .sclk(sclk), .sdi(sdi), .sdo(sdo), .peak_lvl(peak_lvl),
    .regs_q(regs_q), .busy(busy)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NREG; i++) model[i] = 10'((37 * i + 5) % 1024);
  endtask

  task automatic check_regs(input string req);
    for (int i = 0; i < NREG; i++)
      check(req, 32'(regs_q[i*10 +: 10]), 32'(model[i]));
  endtask

  // one frame of nclk serial clocks at 12.5 MHz; rx collects sdo at rising edges
  task automatic xfer(input logic [15:0] w, input int nclk, output logic [15:0] rx);
    rx = '0;
    cs_n = 1'b0;
    #40;
    for (int i = 0; i < nclk; i++) begin
      sdi = (i < 16) ? w[15-i] : 1'b0;
      #40 sclk = 1'b1;
      if (i < 16) rx[15-i] = sdo;
      #40 sclk = 1'b0;
    end
    #40 cs_n = 1'b1;
    #40;
    repeat (8) @(negedge clk);
  endtask

  function automatic logic [15:0] wword(input logic [3:0] a, input logic [9:0] d);
    return {a, 1'b0, 1'b0, d};
  endfunction
  function automatic logic [15:0] rword(input logic [3:0] a);
    return {a, 1'b1, 1'b0, 10'h000};
  endfunction

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) frame_tick = 1'b1;
      @(negedge clk) frame_tick = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic t_reset();
    model_reset();
    @(negedge clk);
    check("R1 busy in reset", 32'(busy), 1);
    check_regs("R1 default in reset");
    check("R8 sdo idle", 32'(sdo), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_regs("R1 default after release");
    check("R1 busy after release", 32'(busy), 1);
  endtask

  task automatic t_busy_drop();
    logic [15:0] rx;
    xfer(wword(4'd2, 10'h155), 16, rx);
    check_regs("R5 write in window dropped");
  endtask

  task automatic t_busy_window();
    ticks(19);
    check("R2 busy before last tick", 32'(busy), 1);
    @(negedge clk) frame_tick = 1'b1;
    @(negedge clk) frame_tick = 1'b0;
    check("R2 busy cleared", 32'(busy), 0);
    ticks(3);
    check("R2 busy stays low", 32'(busy), 0);
    check_regs("R5 dropped write stays dropped");
  endtask

  task automatic t_write();
    logic [15:0] rx;
    xfer(wword(4'd0, 10'h3FF), 16, rx); model[0] = 10'h3FF;
    check("R8 sdo low in write", 32'(rx), 0);
    xfer(wword(4'd3, 10'h0A5), 16, rx); model[3] = 10'h0A5;
    xfer(wword(4'd7, 10'h200), 16, rx); model[7] = 10'h200;
    xfer(wword(4'd2, 10'h001), 16, rx); model[2] = 10'h001;
    check_regs("R3 writes applied");
  endtask

  task automatic t_read();
    logic [15:0] rx;
    for (int a = 0; a < NREG; a++) begin
      xfer(rword(4'(a)), 16, rx);
      check("R6 read data", 32'(rx[9:0]), 32'(model[a]));
      check("R8 sdo low before data", 32'(rx[15:10]), 0);
    end
    check_regs("R6 read leaves regs");
  endtask

  task automatic t_badcount();
    logic [15:0] rx;
    xfer(wword(4'd1, 10'h2AA), 15, rx);
    check_regs("R4 15 clocks discarded");
    xfer(wword(4'd1, 10'h2AA), 17, rx);
    check_regs("R4 17 clocks discarded");
    xfer(wword(4'd1, 10'h2AA), 0, rx);
    check_regs("R4 0 clocks discarded");
  endtask

  task automatic t_peak();
    logic [15:0] rx;
    peak_lvl = {10'h2C3, 10'h11E};
    xfer(rword(4'd14), 16, rx);
    check("R7 peak0", 32'(rx[9:0]), 32'h11E);
    xfer(rword(4'd15), 16, rx);
    check("R7 peak1", 32'(rx[9:0]), 32'h2C3);
    xfer(rword(4'd10), 16, rx);
    check("R7 unmapped reads 0", 32'(rx[9:0]), 0);
    xfer(wword(4'd9, 10'h0FF), 16, rx);
    xfer(wword(4'd14, 10'h0FF), 16, rx);
    check_regs("R7 high-address write ignored");
  endtask

  task automatic t_reset2();
    rst_n = 1'b0;
    model_reset();
    @(negedge clk);
    check_regs("R1 defaults restored");
    check("R1 busy again", 32'(busy), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy after second release", 32'(busy), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_busy_drop();
    t_busy_window();
    t_write();
    t_read();
    t_badcount();
    t_peak();
    t_reset2();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    end
    $finish;
  end

  initial begin
    #3000000;
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    end
    $finish;
  end
endmodule